// File: doc/BRIEF.md
# Timer Clock Prescaler and Divider

This block turns one base clock into a tick enable for each of five timer channels. The channels fall into two groups. Channels 0 and 1 form group 0, and channels 2 to 4 form group 1. Each group has an 8-bit prescaler. A prescaler value P gives one prescaler tick every P+1 base clock cycles.

Each group also has a binary divider chain, driven by its prescaler. The chain offers taps that divide the prescaler rate by 1, 2, 4, 8 and 16. Every channel has a 4-bit selector. The selector picks one of the group's divider taps. For codes marked in an external-clock mask, it instead picks the group's external tick input.

All outputs are single-cycle enables in the base clock domain; no derived clock is produced. The external tick inputs arrive already synchronized as enable pulses.

Software reaches the block through a plain write strobe, a byte address and a combinational read-back. There are two configuration words:

- Address 0x00 holds both prescaler values.
- Address 0x04 holds the five channel selectors.

Each prescaler is built as a two-state machine:

- **PS_RUN** is a counting state.
- **PS_LAST** is the terminal state. The prescaler tick is high whenever the machine is in PS_LAST.

The transitions are:

- **RUN_TO_LAST**: the next count value equals P.
- **LAST_TO_RUN**: the count wraps and P is non-zero.
- **LAST_HOLD**: the machine stays in PS_LAST when P is zero, giving a tick every cycle.
- **RESTART**: a write to word 0 sends the machine to PS_RUN with the count at zero, or to PS_LAST if the new P is zero. This applies from any state.

Reset places both machines in PS_LAST.

Top module: `tcd_top`

## Requirements
- R1: After reset both configuration words read as zero, and every channel tick is high in every cycle, because P=0 and selector code 0 route the undivided prescaler tick.
- R2: Configuration word 0 is at byte address 0x00, with group-0 prescaler in bits 7:0 and group-1 prescaler in bits 15:8; bits 31:16 read zero. Configuration word 1 is at 0x04, with channel n's selector in bits 4n+3:4n; bits 31:20 read zero. Writes to any other address are ignored, and reads from any other address return zero.
- R3: With prescaler value P, the group's prescaler tick repeats every P+1 base clock cycles.
- R4: A write to word 0 restarts both prescalers and both divider chains. After the write edge, a channel dividing by 2^k first ticks in cycle (P+1)·2^k − 1, where cycle 0 is the first cycle after the write edge, and then every (P+1)·2^k cycles.
- R5: A selector code s that is not external and has s+DIV_BASE ≤ 4 divides the prescaler tick rate by 2^(s+DIV_BASE). DIV_BASE defaults to 0.
- R6: A code that is not external but has s+DIV_BASE > 4 behaves as a division by 16.
- R7: A selector code whose bit is set in EXT_MASK makes the channel tick equal the group's external tick input in the same cycle. The default EXT_MASK is 0x00E0, which marks codes 5, 6 and 7.
- R8: Channels 0 and 1 use prescaler 0 and external tick input bit 0. Channels 2, 3 and 4 use prescaler 1 and external tick input bit 1.
- R9: A write to word 1 changes channel routing from the next cycle. It does not disturb the phase of either prescaler or divider chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address of the configuration word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ext_tick | input | 2 | Synchronized external tick enables, one per group |
| ch_tick | output | 5 | Per-channel tick enables |

## Verification
A prescaler machine stuck in the wrong state, or a counter that was not cleared, shows up as a channel tick in the wrong cycle within P+1 cycles of a write to word 0. A divider counter off by one bit shows up by the (P+1)·16th cycle at the latest. A wrong selector decode or a swapped group changes the tick pattern in the very first cycle after the write, because the channels on an external code follow the randomly driven external inputs cycle by cycle. A lost restart, or a spurious restart on a selector write, shifts every later tick and is caught at the next expected tick.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    localparam int NUM_GRP = 2;

    typedef enum logic {
        PS_RUN  = 1'b0,
        PS_LAST = 1'b1
    } ps_state_e;

    // Maps a selector code to a divider tap index, clamped to the top tap.
    function automatic int code_to_step(input int code, input int base, input int max_step);
        int s;
        s = code + base;
        if (s > max_step) s = max_step;
        return s;
    endfunction

endpackage

// File: rtl/tcd_regs.sv
module tcd_regs
    import tcd_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_PRE = 0,
    parameter int ADDR_SEL = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic [NUM_GRP-1:0][PRE_W-1:0]     pre_val,
    output logic [NUM_CH-1:0][SEL_W-1:0]      sel_val,
    output logic                              restart
);

    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;

    logic hit_pre;
    logic hit_sel;

    assign hit_pre = (bus_addr == ADDR_W'(ADDR_PRE));
    assign hit_sel = (bus_addr == ADDR_W'(ADDR_SEL));
    assign restart = bus_wr && hit_pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_val <= '0;
        end else if (restart) begin
            pre_val <= bus_wdata[PRE_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_val <= '0;
        end else if (bus_wr && hit_sel) begin
            sel_val <= bus_wdata[SEL_BITS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_pre) begin
            bus_rdata[PRE_BITS-1:0] = pre_val;
        end else if (hit_sel) begin
            bus_rdata[SEL_BITS-1:0] = sel_val;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/tcd_prescaler.sv
module tcd_prescaler
    import tcd_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] load_val,
    input  logic [PRE_W-1:0] div_val,
    output logic             tick
);

    ps_state_e        state_q, state_d;
    logic [PRE_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_LAST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            cnt_d   = '0;
            state_d = (load_val == '0) ? PS_LAST : PS_RUN;
        end else begin
            unique case (state_q)
                PS_RUN: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_d == div_val) state_d = PS_LAST;
                end
                PS_LAST: begin
                    cnt_d   = '0;
                    state_d = (div_val == '0) ? PS_LAST : PS_RUN;
                end
                default: begin
                    cnt_d   = '0;
                    state_d = PS_LAST;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tick = (state_q == PS_LAST);
    end

endmodule

// File: rtl/tcd_divider.sv
module tcd_divider #(
    parameter int MAX_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              pre_tick,
    output logic [MAX_STEP:0] taps
);

    logic [MAX_STEP-1:0] dcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else if (restart) begin
            dcnt_q <= '0;
        end else if (pre_tick) begin
            dcnt_q <= dcnt_q + 1'b1;
        end
    end

    assign taps[0] = pre_tick;

    for (genvar k = 1; k <= MAX_STEP; k++) begin : g_tap
        assign taps[k] = pre_tick && (&dcnt_q[k-1:0]);
    end

endmodule

// File: rtl/tcd_chan_sel.sv
module tcd_chan_sel
    import tcd_pkg::*;
#(
    parameter int                     SEL_W    = 4,
    parameter int                     MAX_STEP = 4,
    parameter int                     DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0]  EXT_MASK = 16'h00E0
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [MAX_STEP:0] taps,
    input  logic              ext_in,
    output logic              tick
);

    int step;

    always_comb begin
        step = code_to_step(int'(sel), DIV_BASE, MAX_STEP);
        tick = 1'b0;
        if (EXT_MASK[sel]) begin
            tick = ext_in;
        end else begin
            for (int k = 0; k <= MAX_STEP; k++) begin
                if (step == k) tick = taps[k];
            end
        end
    end

endmodule

// File: rtl/tcd_top.sv
module tcd_top
    import tcd_pkg::*;
#(
    parameter int                    NUM_CH   = 5,
    parameter int                    GRP0_CH  = 2,
    parameter int                    PRE_W    = 8,
    parameter int                    SEL_W    = 4,
    parameter int                    MAX_STEP = 4,
    parameter int                    DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0,
    parameter int                    ADDR_W   = 8,
    parameter int                    DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        ext_tick,
    output logic [NUM_CH-1:0] ch_tick
);

    logic [NUM_GRP-1:0][PRE_W-1:0] pre_val;
    logic [NUM_CH-1:0][SEL_W-1:0]  sel_val;
    logic                          restart;
    logic [NUM_GRP-1:0]            pre_tick;
    logic [NUM_GRP-1:0][MAX_STEP:0] grp_taps;

    tcd_regs #(
        .NUM_CH (NUM_CH),
        .PRE_W  (PRE_W),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pre_val   (pre_val),
        .sel_val   (sel_val),
        .restart   (restart)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tcd_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .load_val (bus_wdata[g*PRE_W +: PRE_W]),
            .div_val  (pre_val[g]),
            .tick     (pre_tick[g])
        );

        tcd_divider #(.MAX_STEP(MAX_STEP)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .pre_tick (pre_tick[g]),
            .taps     (grp_taps[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        tcd_chan_sel #(
            .SEL_W    (SEL_W),
            .MAX_STEP (MAX_STEP),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) u_sel (
            .sel    (sel_val[c]),
            .taps   (grp_taps[GRP]),
            .ext_in (ext_tick[GRP]),
            .tick   (ch_tick[c])
        );
    end

endmodule

// File: rtl/tcd_checker.sv
module tcd_checker #(
    parameter int                    NUM_CH   = 5,
    parameter int                    PRE_W    = 8,
    parameter int                    SEL_W    = 4,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [7:0]                bus_addr,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic [1:0]                ext_tick,
    input logic [NUM_CH-1:0]         ch_tick,
    input logic [1:0]                pre_tick,
    input logic [PRE_W-1:0]          pre0,
    input logic [NUM_CH*SEL_W-1:0]   sel_flat
);

    AST_PRE_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata[31:16] == 16'h0)) else $error("AST_PRE_WORD_UPPER"); // R2

    AST_SEL_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h04) |-> (bus_rdata[31:20] == 12'h0)) else $error("AST_SEL_WORD_UPPER"); // R2

    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 8'h00 && bus_addr != 8'h04) |-> (bus_rdata == 32'h0)) else $error("AST_OTHER_ADDR_ZERO"); // R2

    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick[0] && !(bus_wr && bus_addr == 8'h00) && pre0 != '0) |=> !pre_tick[0]) else $error("AST_PRE_SPACING"); // R3

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00 && bus_wdata[PRE_W-1:0] != '0) |=> !pre_tick[0]) else $error("AST_RESTART_QUIET"); // R4

    AST_EXT_FIRST_CH: assert property (@(posedge clk) disable iff (!rst_n)
        EXT_MASK[sel_flat[SEL_W-1:0]] |-> (ch_tick[0] == ext_tick[0])) else $error("AST_EXT_FIRST_CH"); // R7

    AST_EXT_LAST_CH: assert property (@(posedge clk) disable iff (!rst_n)
        EXT_MASK[sel_flat[NUM_CH*SEL_W-1 -: SEL_W]] |-> (ch_tick[NUM_CH-1] == ext_tick[1])) else $error("AST_EXT_LAST_CH"); // R8

endmodule

bind tcd_top tcd_checker #(
    .NUM_CH   (NUM_CH),
    .PRE_W    (PRE_W),
    .SEL_W    (SEL_W),
    .EXT_MASK (EXT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_tick  (ext_tick),
    .ch_tick   (ch_tick),
    .pre_tick  (pre_tick),
    .pre0      (pre_val[0]),
    .sel_flat  (sel_val)
);

// File: tb/tcd_top_tb.sv
module tcd_top_tb;

    localparam int          NCH   = 5;
    localparam int          BASE  = 0;
    localparam logic [15:0] EXTM  = 16'h00E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  ext_tick = 2'b00;
    logic [NCH-1:0] ch_tick;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [19:0] sel_m = '0;
    int          pre_m [2];
    int          cyc   = 0;

    always #10 clk = ~clk;

    tcd_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .ch_tick   (ch_tick)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic exp_tick(input int ch, input int c);
        int g, code, step, per;
        g    = (ch < 2) ? 0 : 1;
        code = int'(sel_m[4*ch +: 4]);
        if (EXTM[code]) return ext_tick[g];
        step = code + BASE;
        if (step > 4) step = 4;
        per = (pre_m[g] + 1) << step;
        return ((c + 1) % per) == 0;
    endfunction

    function automatic string req_of(input int ch);
        int code;
        code = int'(sel_m[4*ch +: 4]);
        if (EXTM[code]) return (ch < 2) ? "R7" : "R7/R8";
        if (code + BASE > 4) return "R6";
        return "R3/R4/R5/R8";
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_addr = 8'h00;
        if (a == 8'h00) begin
            pre_m[0] = int'(d[7:0]);
            pre_m[1] = int'(d[15:8]);
            cyc = 0;
        end else begin
            if (a == 8'h04) sel_m = d[19:0];
            cyc++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_tick = 2'($urandom);
            #1;
            for (int ch = 0; ch < NCH; ch++) begin
                check(ch_tick[ch] === exp_tick(ch, cyc), req_of(ch), 32'(ch_tick[ch]), 32'(exp_tick(ch, cyc)));
            end
            cyc++;
        end
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
        bus_addr = 8'h00;
    endtask

    initial begin
        void'($urandom(32'd1234));
        pre_m[0] = 0; pre_m[1] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        read_check(8'h00, 32'h0, "R1");
        read_check(8'h04, 32'h0, "R1");
        @(negedge clk); ext_tick = 2'b00; #1;
        check(ch_tick === 5'h1f, "R1", 32'(ch_tick), 32'h1f);

        // R3 R4 R8: undivided taps, different prescalers per group
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, 32'h0000_0502);
        run(40);

        // R5: each legal divider code
        bus_write(8'h04, 32'h0003_2401);
        bus_write(8'h00, 32'h0000_0001);
        run(80);

        // R6 R7: external codes and oversize codes
        bus_write(8'h04, 32'h000F_9765);
        bus_write(8'h00, 32'h0000_0300);
        run(100);

        // R9: selector change mid-run keeps phase
        bus_write(8'h04, 32'h0001_2340);
        bus_write(8'h00, 32'h0000_0102);
        run(21);
        bus_write(8'h04, 32'h0004_3215);
        run(60);

        // R2: register map and ignored addresses
        bus_write(8'h00, 32'hABCD_1234);
        bus_write(8'h04, 32'hFFF1_2345);
        bus_write(8'h08, 32'h5555_5555);
        read_check(8'h00, 32'h0000_1234, "R2");
        read_check(8'h04, 32'h0001_2345, "R2");
        read_check(8'h08, 32'h0000_0000, "R2");
        read_check(8'h3C, 32'h0000_0000, "R2");

        // Random mixes
        for (int it = 0; it < 20; it++) begin
            logic [31:0] s, p;
            s = $urandom;
            p = {16'h0, 5'($urandom), 3'($urandom), 5'($urandom), 3'($urandom)} & 32'h0000_0707;
            bus_write(8'h04, s);
            bus_write(8'h00, p);
            run(60 + int'($urandom % 90));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule